// File: doc/BRIEF.md
# Mask-Driven Bit-Field Extract/Insert Unit

This unit moves a bit field between an 8-bit register value and a byte held in memory. A single 8-bit mask gives both the position and the width of the field. The shift amount is the index of the lowest set bit in the mask, and that index comes from a priority encoder. There is no separate offset or length operand.

An extract reads one byte through the memory port. It keeps only the masked bits and presents them right-justified on the `result` output.

An insert is an atomic read-modify-write. It reads the destination byte and shifts the register value up to the field position. It then replaces only the masked bits of the destination and writes the merged byte back. Bits outside the mask keep their old values, and register bits shifted above bit 7 are lost.

The unit takes a new command only while it is idle. `busy` stays high from the accepting edge until `done`. `done` pulses for one cycle when an extract result is valid or when an insert's write has been acknowledged.

Top module: `bitfield_unit`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `mem_valid`, `mem_we` and `result` are all 0.
- R2: An extract (`op`=0) drives `result` to (memory byte AND mask) shifted right by the index of the mask's lowest set bit. With byte 0xA5: mask 0xF0 gives 0x0A, 0x3C gives 0x09, 0xFE gives 0x52, 0x07 gives 0x05 and 0xE0 gives 0x05.
- R3: A single-bit mask extracts a 1-bit field. With byte 0xA5, masks 0x01, 0x20 and 0x80 give 1, and masks 0x02, 0x10 and 0x40 give 0.
- R4: A mask of 0x00 gives an extract result of 0x00, and an insert writes back the destination byte unchanged.
- R5: An insert (`op`=1) writes ((reg_val shifted left by the lowest set bit index) AND mask) OR (destination AND NOT mask), and register bits shifted past bit 7 are dropped. With reg_val 0xA5 and destination 0x00: mask 0xF0 gives 0x50, 0xE0 gives 0xA0, 0x38 gives 0x28 and 0xFE gives 0x4A.
- R6: An insert keeps the destination bits outside the mask. reg_val 0xA5 with mask 0x3C into 0xC3 writes 0xD7.
- R7: An extract performs exactly one read and no write. `busy` is 1 from the cycle after `start` is accepted until `done`. `done` is high for exactly one cycle, in the cycle after the read is acknowledged, and `busy` is 0 in that cycle.
- R8: An insert performs exactly one read and then exactly one write. `done` pulses in the cycle after the write is acknowledged.
- R9: A `start` seen while `busy` is 1 is ignored: the running operation completes unchanged and no extra memory access occurs.
- R10: An insert leaves `result` unchanged.
- R11: While `mem_valid` is 1 and `mem_ready` is 0, the request is held: `mem_valid`, `mem_we` and `mem_wdata` stay stable into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start an operation; only taken while idle |
| op | input | 1 | 0 = extract, 1 = insert |
| mask | input | 8 | Field mask |
| reg_val | input | 8 | Register operand for insert |
| result | output | 8 | Right-justified extract result |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Memory accepts or answers the request |

## Verification
The hardest case to reach from the ports is a request held through a stall, where `start` toggles while the unit waits on memory. The bench runs the memory model with latencies from zero to three cycles. One task raises a competing `start`, with a different op and mask, during a slow insert's read phase. It then counts the reads and writes seen at the port and checks the written byte, to show the competing command did nothing.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
    localparam int DATA_W  = 8;
    localparam int SHIFT_W = $clog2(DATA_W);

    typedef enum logic {
        OP_EXTRACT = 1'b0,
        OP_INSERT  = 1'b1
    } bfu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bfu_state_e;

    typedef struct packed {
        bfu_op_e             op;
        logic [DATA_W-1:0]   mask;
        logic [DATA_W-1:0]   val;
    } bfu_cmd_t;

    typedef struct packed {
        logic [DATA_W-1:0] ext;
        logic [DATA_W-1:0] ins;
    } bfu_alu_t;
endpackage

// File: rtl/bfu_lsb_enc.sv
module bfu_lsb_enc #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/bfu_field_alu.sv
module bfu_field_alu
    import bfu_pkg::*;
(
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] val,
    input  logic [DATA_W-1:0] mem_byte,
    output bfu_alu_t          res
);
    logic [SHIFT_W-1:0] sh;
    logic [DATA_W-1:0]  val_up;
    logic [DATA_W-1:0]  picked;

    bfu_lsb_enc #(.W(DATA_W), .IW(SHIFT_W)) enc_i (
        .vec (mask),
        .idx (sh)
    );

    assign picked = mem_byte & mask;
    assign val_up = val << sh;

    genvar b;
    generate
        for (b = 0; b < DATA_W; b++) begin : g_merge
            assign res.ins[b] = mask[b] ? val_up[b] : mem_byte[b];
        end
    endgenerate

    assign res.ext = picked >> sh;
endmodule

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
    import bfu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  bfu_cmd_t          cmd_in,
    input  bfu_alu_t          alu,
    input  logic              mem_ready,
    output bfu_cmd_t          cmd_q,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] result,
    output logic              busy,
    output logic              done
);
    bfu_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cmd_q     <= '0;
            mem_wdata <= '0;
            result    <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cmd_q   <= cmd_in;
                        state_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_ready) begin
                        if (cmd_q.op == OP_EXTRACT) begin
                            result  <= alu.ext;
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            mem_wdata <= alu.ins;
                            state_q   <= ST_WRITE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_ready) begin
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_valid = (state_q != ST_IDLE);
    assign mem_we    = (state_q == ST_WRITE);
    assign busy      = (state_q != ST_IDLE);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) && $stable(mem_wdata)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    write_only_insert_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (cmd_q.op == OP_INSERT));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_q.op == OP_INSERT) |=> $stable(result));

    // R4
    zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (done && cmd_q.op == OP_EXTRACT && cmd_q.mask == '0) |-> (result == '0));
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bfu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] reg_val,
    output logic [DATA_W-1:0] result,
    output logic              busy,
    output logic              done,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    bfu_cmd_t cmd_in;
    bfu_cmd_t cmd_q;
    bfu_alu_t alu;

    assign cmd_in.op   = bfu_op_e'(op);
    assign cmd_in.mask = mask;
    assign cmd_in.val  = reg_val;

    bfu_field_alu alu_i (
        .mask     (cmd_q.mask),
        .val      (cmd_q.val),
        .mem_byte (mem_rdata),
        .res      (alu)
    );

    bfu_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd_in    (cmd_in),
        .alu       (alu),
        .mem_ready (mem_ready),
        .cmd_q     (cmd_q),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .result    (result),
        .busy      (busy),
        .done      (done)
    );

    // R9
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(cmd_q));
endmodule

// File: tb/bitfield_unit_tb_top.sv
module bitfield_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       op = 1'b0;
    logic [7:0] mask = '0;
    logic [7:0] reg_val = '0;
    logic [7:0] result;
    logic       busy, done, mem_valid, mem_we;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = '0;
    logic       mem_ready = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem_byte = '0;
    int         lat = 0;
    int         wcnt = 0;
    int         rd_cnt = 0;
    int         wr_cnt = 0;
    logic [7:0] last_wr = '0;

    always #2 clk = ~clk;

    bitfield_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op), .mask(mask),
        .reg_val(reg_val), .result(result), .busy(busy), .done(done),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // memory model: answers on the falling edge after lat waiting cycles
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (mem_valid) begin
            if (wcnt >= lat) begin
                mem_ready = 1'b1;
                mem_rdata = mem_byte;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            if (mem_we) begin
                wr_cnt  <= wr_cnt + 1;
                last_wr <= mem_wdata;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    function automatic logic [7:0] ref_ext(input logic [7:0] m, input logic [7:0] d);
        int s = 0;
        for (int i = 0; i < 8; i++) if (m[i]) begin s = i; break; end
        return (d & m) >> s;
    endfunction

    function automatic logic [7:0] ref_ins(input logic [7:0] m, input logic [7:0] v, input logic [7:0] d);
        int s = 0;
        for (int i = 0; i < 8; i++) if (m[i]) begin s = i; break; end
        return ((v << s) & m) | (d & ~m);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one operation; returns result, busy seen after accept, done width, counts
    task automatic run_op(input logic o, input logic [7:0] m, input logic [7:0] v,
                          input logic [7:0] d, input int l,
                          output logic [7:0] res, output logic busy_seen,
                          output int rds, output int wrs, output logic [7:0] wr_val);
        int cyc = 0;
        int r0 = rd_cnt;
        int w0 = wr_cnt;
        mem_byte = d;
        lat = l;
        @(negedge clk);
        start = 1'b1; op = o; mask = m; reg_val = v;
        @(negedge clk);
        start = 1'b0;
        busy_seen = busy;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) check("R7 done timeout", 0, 1);
        else check("R7 busy low with done", busy, 0);
        res = result;
        @(negedge clk);
        check("R7 done one cycle", done, 0);
        rds = rd_cnt - r0;
        wrs = wr_cnt - w0;
        wr_val = last_wr;
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 mem_valid", mem_valid, 0);
        check("R1 mem_we", mem_we, 0);
        check("R1 result", result, 0);
    endtask

    task automatic t_extract();
        logic [7:0] masks[5] = '{8'hF0, 8'h3C, 8'hFE, 8'h07, 8'hE0};
        logic [7:0] exps[5]  = '{8'h0A, 8'h09, 8'h52, 8'h05, 8'h05};
        logic [7:0] r, w; logic b; int rc, wc;
        for (int i = 0; i < 5; i++) begin
            run_op(1'b0, masks[i], 8'h00, 8'hA5, i % 4, r, b, rc, wc, w);
            check("R2 extract", r, exps[i]);
            check("R2 extract ref", r, ref_ext(masks[i], 8'hA5));
        end
        run_op(1'b0, 8'h6C, 8'h00, 8'h3B, 2, r, b, rc, wc, w);
        check("R2 extract other operand", r, ref_ext(8'h6C, 8'h3B));
    endtask

    task automatic t_single_bit();
        logic [7:0] masks[6] = '{8'h01, 8'h20, 8'h80, 8'h02, 8'h10, 8'h40};
        logic [7:0] exps[6]  = '{8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
        logic [7:0] r, w; logic b; int rc, wc;
        for (int i = 0; i < 6; i++) begin
            run_op(1'b0, masks[i], 8'h00, 8'hA5, 0, r, b, rc, wc, w);
            check("R3 single bit", r, exps[i]);
        end
    endtask

    task automatic t_zero_mask();
        logic [7:0] r, w; logic b; int rc, wc;
        run_op(1'b0, 8'h00, 8'h00, 8'hA5, 1, r, b, rc, wc, w);
        check("R4 extract zero mask", r, 8'h00);
        run_op(1'b1, 8'h00, 8'hA5, 8'h6E, 1, r, b, rc, wc, w);
        check("R4 insert zero mask writes", wc, 1);
        check("R4 insert zero mask data", w, 8'h6E);
    endtask

    task automatic t_insert();
        logic [7:0] masks[4] = '{8'hF0, 8'hE0, 8'h38, 8'hFE};
        logic [7:0] exps[4]  = '{8'h50, 8'hA0, 8'h28, 8'h4A};
        logic [7:0] r, w; logic b; int rc, wc;
        for (int i = 0; i < 4; i++) begin
            run_op(1'b1, masks[i], 8'hA5, 8'h00, i, r, b, rc, wc, w);
            check("R5 insert", w, exps[i]);
            check("R5 insert ref", w, ref_ins(masks[i], 8'hA5, 8'h00));
        end
    endtask

    task automatic t_merge();
        logic [7:0] r, w; logic b; int rc, wc;
        run_op(1'b1, 8'h3C, 8'hA5, 8'hC3, 2, r, b, rc, wc, w);
        check("R6 merge", w, 8'hD7);
        run_op(1'b1, 8'h81, 8'h03, 8'h5A, 0, r, b, rc, wc, w);
        check("R6 split mask merge", w, ref_ins(8'h81, 8'h03, 8'h5A));
    endtask

    task automatic t_access_order();
        logic [7:0] r, w; logic b; int rc, wc;
        run_op(1'b0, 8'h0F, 8'h00, 8'hA5, 3, r, b, rc, wc, w);
        check("R7 extract busy after accept", b, 1);
        check("R7 extract reads", rc, 1);
        check("R7 extract writes", wc, 0);
        run_op(1'b1, 8'h0F, 8'hA5, 8'hFF, 3, r, b, rc, wc, w);
        check("R8 insert busy after accept", b, 1);
        check("R8 insert reads", rc, 1);
        check("R8 insert writes", wc, 1);
        check("R8 insert data", w, 8'hF5);
    endtask

    task automatic t_start_busy();
        int r0 = rd_cnt;
        int w0 = wr_cnt;
        int cyc = 0;
        mem_byte = 8'h00;
        lat = 3;
        @(negedge clk);
        start = 1'b1; op = 1'b1; mask = 8'hF0; reg_val = 8'hA5;
        @(negedge clk);
        op = 1'b0; mask = 8'h0F; reg_val = 8'h11;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        check("R9 done seen", done, 1);
        @(negedge clk);
        repeat (4) @(negedge clk);
        check("R9 reads", rd_cnt - r0, 1);
        check("R9 writes", wr_cnt - w0, 1);
        check("R9 data of first command", last_wr, 8'h50);
        check("R9 idle afterwards", busy, 0);
    endtask

    task automatic t_result_hold();
        logic [7:0] r, w; logic b; int rc, wc;
        run_op(1'b0, 8'hF0, 8'h00, 8'hA5, 0, r, b, rc, wc, w);
        check("R10 setup", r, 8'h0A);
        run_op(1'b1, 8'h0F, 8'h77, 8'h00, 1, r, b, rc, wc, w);
        check("R10 result kept", r, 8'h0A);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_extract();
        t_single_bit();
        t_zero_mask();
        t_insert();
        t_merge();
        t_access_order();
        t_start_busy();
        t_result_hold();
        // R11 is exercised by every latency above 0 in the memory model
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule